// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block sits between a set of I/O devices and a processor core and decides which device interrupt the core services next. Software gives every device one of eight priority levels through a configuration write port. Level 0 switches a device's interrupts off. Levels 1 to 7 are live, and level 1 is the most urgent. All requests at one level merge into a single request for that level.

The block keeps a mask of the levels that are in service. A level can be granted only while no level of the same or higher priority is in that mask. A more urgent request can therefore nest on top of a less urgent handler. The grant waits for the core to signal an instruction-boundary memory-read point. The block then emits a one-cycle take strobe together with the level and the address of the first of that level's two vector words. A level stays in service until the handler pulses the dismiss input. Each dismiss pulse retires the most urgent level that is in service. A registered status output names the lowest-numbered device that is requesting at the most urgent requesting level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `take` is 0, `in_service` is all zero, `pend_valid` is 0, and every device is at level 0 (disabled).
- R2: A device configured to level 0 never causes `take`, even while its request line is high.
- R3: `take` rises only in the cycle after a clock edge at which `fetch_pt` was high. A pending request with `fetch_pt` low produces no `take`.
- R4: On `take`, `take_lvl` equals the granted level L and `vec_addr` equals VEC_BASE + 2*L. With the default base of 40, level 1 gives 42 and level 5 gives 50.
- R5: When several levels request at once, the lowest-numbered nonzero level is granted.
- R6: Level L is granted only if no level in the range 1..L is in service. A request at a level numerically below every in-service level preempts them and nests.
- R7: `in_service` bit L-1 (bit 0 is level 1) is set in the cycle `take` is presented for level L. It stays set until a `dismiss` pulse. Each `dismiss` clears only the lowest-numbered set bit.
- R8: Devices requesting at the same level merge into that level's single request. One cycle after the inputs settle, `pend_valid`, `pend_lvl` and `pend_dev` report the most urgent requesting level and the lowest-numbered device requesting at it.
- R9: A configuration write (`cfg_we`, `cfg_dev`, `cfg_lvl`) takes effect from the next clock edge and can move a device between levels.
- R10: `take` is a single-cycle pulse per acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_DEV | Request line of each device |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dev | input | DEV_W | Device number to configure |
| cfg_lvl | input | 3 | Level to assign (0 disables) |
| fetch_pt | input | 1 | Core is at the memory-read point of an instruction |
| dismiss | input | 1 | Retire the most urgent in-service level |
| take | output | 1 | One-cycle interrupt acceptance strobe |
| take_lvl | output | 3 | Level accepted |
| vec_addr | output | ADDR_W | Address of the first vector word |
| in_service | output | 7 | In-service mask, bit 0 is level 1 |
| pend_valid | output | 1 | Some enabled device is requesting |
| pend_lvl | output | 3 | Most urgent requesting level |
| pend_dev | output | DEV_W | Lowest-numbered device requesting at that level |

## Verification
The bench builds the block with NUM_DEV = 16, which gives a 4-bit device number. The vector base and address width keep their default values. Sixteen devices still allow several devices to share one level, a device at each end of the number range, and live requests at levels 1, 2, 3, 5 and 6 at the same time. Nesting, blocking at equal and lower priority, the priority-ordered dismiss, and the lowest-numbered-device choice in the status output can therefore all be exercised quickly at the port level.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;

  // index of lowest set bit, 0 when none set
  function automatic lvl_t lowest_lvl(input lvl_vec_t v);
    lvl_t r;
    r = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (v[i]) r = lvl_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_level_table.sv
module pic_level_table
  import pic_pkg::*;
#(
  parameter int NUM_DEV = 128,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [DEV_W-1:0]   cfg_dev,
  input  lvl_t               cfg_lvl,
  input  logic [NUM_DEV-1:0] dev_req,
  output lvl_vec_t           lvl_req,
  output logic               top_vld,
  output lvl_t               top_lvl,
  output logic [DEV_W-1:0]   top_dev
);
  lvl_t lvl_q [NUM_DEV];
  logic [NUM_LVL-1:0][NUM_DEV-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NUM_DEV; d++) lvl_q[d] <= '0;
    end else if (cfg_we && (int'(cfg_dev) < NUM_DEV)) begin
      lvl_q[cfg_dev] <= cfg_lvl;
    end
  end

  // per-level request merge; level 0 never requests
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      if (l == 0) begin : g_off
        assign hit[l][d] = 1'b0;
      end else begin : g_on
        assign hit[l][d] = dev_req[d] && (lvl_q[d] == lvl_t'(l));
      end
    end
    assign lvl_req[l] = |hit[l];
  end

  always_comb begin
    top_vld = |lvl_req;
    top_lvl = lowest_lvl(lvl_req);
    top_dev = '0;
    for (int d = NUM_DEV - 1; d >= 0; d--) begin
      if (hit[top_lvl][d]) top_dev = DEV_W'(d);
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  lvl_vec_t lvl_req,
  input  lvl_vec_t in_svc,
  output logic     grant_vld,
  output lvl_t     grant_lvl
);
  lvl_vec_t blocked;
  lvl_vec_t eligible;

  // blocked[L] = any level 1..L in service
  assign blocked[0] = in_svc[0];
  for (genvar l = 1; l < NUM_LVL; l++) begin : g_pfx
    assign blocked[l] = blocked[l-1] | in_svc[l];
  end

  assign eligible  = lvl_req & ~blocked;
  assign grant_vld = |eligible;
  assign grant_lvl = lowest_lvl(eligible);
endmodule

// File: rtl/pic_service.sv
module pic_service
  import pic_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     set_vld,
  input  lvl_t     set_lvl,
  input  logic     dismiss,
  output lvl_vec_t in_svc
);
  lvl_vec_t svc_q;
  lvl_vec_t clr_1h;
  lvl_vec_t set_1h;

  assign clr_1h = dismiss ? (svc_q & (~svc_q + lvl_vec_t'(1))) : '0;
  assign set_1h = set_vld ? (lvl_vec_t'(1) << set_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) svc_q <= '0;
    else     svc_q <= (svc_q & ~clr_1h) | set_1h;
  end

  assign in_svc = svc_q;

  a_r7_dismiss_one: assert property (@(posedge clk) disable iff (rst)
    (dismiss && !set_vld && svc_q != '0) |=> ($countones(svc_q) + 1 == $countones($past(svc_q))));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!dismiss) |=> ((svc_q & $past(svc_q)) == $past(svc_q)));
  a_r1_level0_idle: assert property (@(posedge clk) disable iff (rst)
    svc_q[0] == 1'b0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_DEV  = 128,
  parameter int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int ADDR_W   = 18,
  parameter int VEC_BASE = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               cfg_we,
  input  logic [DEV_W-1:0]   cfg_dev,
  input  logic [2:0]         cfg_lvl,
  input  logic               fetch_pt,
  input  logic               dismiss,
  output logic               take,
  output logic [2:0]         take_lvl,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [6:0]         in_service,
  output logic               pend_valid,
  output logic [2:0]         pend_lvl,
  output logic [DEV_W-1:0]   pend_dev
);
  lvl_vec_t         lvl_req, svc;
  logic             grant_vld, top_vld, accept;
  lvl_t             grant_lvl, top_lvl;
  logic [DEV_W-1:0] top_dev;

  pic_level_table #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_lvl(cfg_lvl),
    .dev_req(dev_req), .lvl_req(lvl_req),
    .top_vld(top_vld), .top_lvl(top_lvl), .top_dev(top_dev)
  );

  pic_arbiter u_arb (
    .lvl_req(lvl_req), .in_svc(svc), .grant_vld(grant_vld), .grant_lvl(grant_lvl)
  );

  assign accept = fetch_pt && grant_vld;

  pic_service u_svc (
    .clk(clk), .rst(rst), .set_vld(accept), .set_lvl(grant_lvl),
    .dismiss(dismiss), .in_svc(svc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take       <= 1'b0;
      take_lvl   <= '0;
      vec_addr   <= '0;
      pend_valid <= 1'b0;
      pend_lvl   <= '0;
      pend_dev   <= '0;
    end else begin
      take       <= accept;
      pend_valid <= top_vld;
      pend_lvl   <= top_lvl;
      pend_dev   <= top_dev;
      if (accept) begin
        take_lvl <= grant_lvl;
        vec_addr <= ADDR_W'(VEC_BASE) + ADDR_W'({grant_lvl, 1'b0});
      end
    end
  end

  assign in_service = svc[NUM_LVL-1:1];

  a_r3_take_on_fetch: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(fetch_pt));
  a_r2_no_level0: assert property (@(posedge clk) disable iff (rst)
    take |-> (take_lvl != 3'd0));
  a_r6_not_blocked: assert property (@(posedge clk) disable iff (rst)
    take |-> (($past(svc) & ((lvl_vec_t'(2) << take_lvl) - lvl_vec_t'(1))) == '0));
  a_r7_marked: assert property (@(posedge clk) disable iff (rst)
    take |-> svc[take_lvl]);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int ND = 16;
  localparam int DW = 4;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic [ND-1:0] dev_req;
  logic          cfg_we;
  logic [DW-1:0] cfg_dev;
  logic [2:0]    cfg_lvl;
  logic          fetch_pt, dismiss;
  logic          take;
  logic [2:0]    take_lvl;
  logic [AW-1:0] vec_addr;
  logic [6:0]    in_service;
  logic          pend_valid;
  logic [2:0]    pend_lvl;
  logic [DW-1:0] pend_dev;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_DEV(ND), .DEV_W(DW), .ADDR_W(AW), .VEC_BASE(40)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .dev_req(dev_req), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
    .cfg_lvl(cfg_lvl), .fetch_pt(fetch_pt), .dismiss(dismiss), .take(take),
    .take_lvl(take_lvl), .vec_addr(vec_addr), .in_service(in_service),
    .pend_valid(pend_valid), .pend_lvl(pend_lvl), .pend_dev(pend_dev)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compares every take against the scoreboard queue (R4, R10)
  always @(negedge clk) begin
    if (!rst && take) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: actual unexpected take lvl %0d expected none", take_lvl);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (take_lvl != 3'(e) || vec_addr != AW'(40 + 2 * e)) begin
          errors++;
          $display("FAIL R4: actual lvl %0d vec %0d expected lvl %0d vec %0d",
                   take_lvl, vec_addr, e, 40 + 2 * e);
        end
      end
    end
  end

  task automatic cfg(input int dev, input int lvl);
    cfg_we = 1'b1; cfg_dev = DW'(dev); cfg_lvl = 3'(lvl);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one fetch point; exp = expected level, 0 for none
  task automatic fetch(input int exp);
    fetch_pt = 1'b1;
    if (exp != 0) exp_q.push_back(exp);
    @(negedge clk);
    fetch_pt = 1'b0;
    @(negedge clk);
  endtask

  task automatic dismiss_one();
    dismiss = 1'b1;
    @(negedge clk);
    dismiss = 1'b0;
  endtask

  initial begin
    rst = 1'b1; dev_req = '0; cfg_we = 1'b0; cfg_dev = '0; cfg_lvl = '0;
    fetch_pt = 1'b0; dismiss = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 take", int'(take), 0);
    check("R1 in_service", int'(in_service), 0);
    check("R1 pend_valid", int'(pend_valid), 0);

    // R2: device at level 0 (reset default) requesting
    dev_req[3] = 1'b1;
    @(negedge clk);
    fetch(0);
    check("R2 in_service", int'(in_service), 0);
    check("R2 pend_valid", int'(pend_valid), 0);

    // R9 + R3: enable device 3 at level 5, no fetch point yet
    cfg(3, 5);
    repeat (3) @(negedge clk);
    check("R3 no take without fetch", int'(take), 0);
    check("R9 pend_lvl", int'(pend_lvl), 5);
    fetch(5);
    check("R7 in_service L5", int'(in_service), 7'b0010000);
    check("R10 take dropped", int'(take), 0);

    // R6: equal level blocked, lower priority blocked
    fetch(0);
    cfg(7, 6);
    dev_req[7] = 1'b1;
    @(negedge clk);
    fetch(0);
    check("R6 blocked", int'(in_service), 7'b0010000);

    // R6: level 2 nests on top of 5
    cfg(9, 2);
    dev_req[9] = 1'b1;
    @(negedge clk);
    fetch(2);
    check("R6 nested", int'(in_service), 7'b0010010);
    dev_req[9] = 1'b0;

    // R7: dismiss retires level 2 only
    dismiss_one();
    @(negedge clk);
    check("R7 dismiss top", int'(in_service), 7'b0010000);
    fetch(0);
    dismiss_one();
    @(negedge clk);
    check("R7 dismiss last", int'(in_service), 0);

    // R5: levels 5 and 6 pending, 5 wins
    fetch(5);
    check("R5 lowest level", int'(in_service), 7'b0010000);
    dismiss_one();
    dev_req = '0;

    // R8: devices 4 and 11 share level 3; devices 0 and 15 at level 6
    cfg(4, 3); cfg(11, 3); cfg(0, 6); cfg(15, 6);
    dev_req[11] = 1'b1; dev_req[4] = 1'b1; dev_req[15] = 1'b1; dev_req[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 pend_valid", int'(pend_valid), 1);
    check("R8 pend_lvl", int'(pend_lvl), 3);
    check("R8 pend_dev", int'(pend_dev), 4);
    fetch(3);
    check("R8 merged single level", int'(in_service), 7'b0000100);
    dev_req[4] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pend_dev next", int'(pend_dev), 11);
    dev_req[11] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pend_dev level 6", int'(pend_dev), 0);

    // R9: move device 15 to level 1; preempts level 3, vector 42
    cfg(15, 1);
    @(negedge clk);
    fetch(1);
    check("R9 moved to L1", int'(in_service), 7'b0000101);
    dismiss_one(); dismiss_one();
    @(negedge clk);
    check("R7 all dismissed", int'(in_service), 0);
    // back-to-back fetch points while L1 pending: only one take (R10)
    fetch_pt = 1'b1; exp_q.push_back(1);
    repeat (2) @(negedge clk);
    fetch_pt = 1'b0;
    @(negedge clk);
    check("R10 one take per accept", int'(in_service), 7'b0000001);
    dev_req = '0;
    repeat (2) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule